// File: doc/BRIEF.md
# Timer-Driven Output Compare Channel

This block is one compare channel that sits beside a free-running timer. It compares the timer value against a primary compare value and a secondary compare value, and it drives a single output pin from those matches. A 3-bit mode selects what the matches do. The pin can latch high or low once, invert on every match, make one delayed pulse, make a pulse in every timer cycle, or run as a pulse-width modulator. That modulator can also be protected by an active-low fault input. Each mode fixes the level the pin takes when the mode is loaded, and each mode has its own rule for which pin edges raise the one-cycle interrupt output.

The mode and both compare values are loaded together by a write strobe. That write is honoured only while the timer is stopped. In the disabled mode the pin is handed back to a general-purpose level input. The timer, its period register and any bus interface sit outside the block. The timer reports a period match on a separate strobe.

Top module: `ocmp_unit`

## Requirements
- R1: With mode 000 loaded, `oc_pin` equals `gpio_lvl` in every cycle, and `oc_irq` stays 0.
- R2: On the clock edge that accepts a write, the pin level is set from the new mode. It is 0 for modes 001, 100 and 101, and 1 for mode 010. For mode 011 it keeps the level `oc_pin` showed just before the write.
- R3: On the clock edge that accepts a write of mode 110 or 111, the pin becomes 1 if the new primary value is non-zero, and 0 if it is zero.
- R4: In mode 001 a primary match drives the pin to 1, and it stays 1 until the next write. Mode 010 does the same but drives the pin to 0.
- R5: In mode 011 every primary match inverts the pin.
- R6: In mode 100, while the one pulse has not yet ended, a primary match drives the pin to 1. A secondary match while the pin is 1 drives it to 0 and ends all further activity until the next write. The secondary-match rule takes precedence over the primary-match rule.
- R7: In mode 101 a primary match drives the pin to 1 and a secondary match drives it to 0, in every timer cycle. If both matches occur in the same cycle, the secondary match wins.
- R8: In modes 110 and 111 the period strobe `prd_hit` drives the pin to 1, and a secondary match drives it to 0. If both occur in the same cycle, the period strobe wins.
- R9: In mode 111, `flt_n` is sampled through one register. A sampled low sets the sticky flag `flt_flag` and forces the pin to 0. While the flag is set the pin stays 0 and ignores the period strobe and the secondary match. Any accepted write clears the flag.
- R10: `oc_irq` is a one-cycle pulse that appears in the same cycle the pin shows its new level. It fires on a rising pin edge in mode 001, on a falling pin edge in modes 010, 100 and 101, and on either pin edge in mode 011. It never fires in mode 110. In mode 111 it fires when the fault flag gets set. It never fires on the edge that accepts a write.
- R11: A write strobe `cfg_we` given while `tmr_run` is 1 is ignored. The mode, both compare values and the pin are unaffected.
- R12: A match counts only while `tmr_run` is 1, and only in the first cycle in which the timer equals the compare value. A timer that holds that value for several cycles produces one match.
- R13: After reset the mode is 000, so `oc_pin` follows `gpio_lvl`, and `oc_irq` and `flt_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | TW | Current timer count |
| tmr_run | input | 1 | Timer is counting |
| prd_hit | input | 1 | Timer period-match strobe |
| cfg_we | input | 1 | Load mode and compare values |
| cfg_mode | input | 3 | Mode to load |
| cfg_pri | input | TW | Primary compare value to load |
| cfg_sec | input | TW | Secondary compare value to load |
| flt_n | input | 1 | Active-low fault input |
| gpio_lvl | input | 1 | Pin level used in mode 000 |
| oc_pin | output | 1 | Compare output pin |
| oc_irq | output | 1 | Interrupt pulse |
| flt_flag | output | 1 | Sticky fault flag |

## Verification
The hardest states to reach are those that need a match and a second event in the same cycle. One is a secondary match together with the period strobe, and another is a primary match together with a secondary match. A further case is a fault that arrives while the modulator would otherwise drive the pin high. The bench sweeps small grids of primary, secondary and period values. The grids include values equal to each other, equal to zero and equal to the period, and a fault pulse is placed in the middle of a run. A cycle model built from the requirements predicts every cycle. Separate runs hold the timer on the compare value, and attempt writes while the timer runs, so that the edge detection and the write gate are exercised apart from the sweep.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   typedef enum logic [2:0] {
      OC_OFF   = 3'd0,
      OC_SET1  = 3'd1,
      OC_SET0  = 3'd2,
      OC_TOG   = 3'd3,
      OC_DLY   = 3'd4,
      OC_PULSE = 3'd5,
      OC_PWM   = 3'd6,
      OC_PWMF  = 3'd7
   } oc_mode_e;
endpackage

// File: rtl/ocmp_cfg.sv
module ocmp_cfg
   import ocmp_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          run,
   input  logic [2:0]    mode_i,
   input  logic [TW-1:0] pri_i,
   input  logic [TW-1:0] sec_i,
   output oc_mode_e      mode_q,
   output logic [TW-1:0] pri_q,
   output logic [TW-1:0] sec_q,
   output logic          load
);
   // writes are accepted only with the timer stopped
   assign load = we & ~run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= OC_OFF;
         pri_q  <= '0;
         sec_q  <= '0;
      end else if (load) begin
         mode_q <= oc_mode_e'(mode_i);
         pri_q  <= pri_i;
         sec_q  <= sec_i;
      end
   end

   assert_run_blocks_write_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      run |=> ($stable(mode_q) && $stable(pri_q) && $stable(sec_q)));
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] tmr,
   input  logic [TW-1:0] pri,
   input  logic [TW-1:0] sec,
   output logic          hit_pri,
   output logic          hit_sec
);
   localparam int NREF = 2;

   logic [NREF-1:0][TW-1:0] refv;
   logic [NREF-1:0]         eq;
   logic [NREF-1:0]         eq_q;
   logic [NREF-1:0]         hit;

   assign refv[0] = pri;
   assign refv[1] = sec;

   for (genvar i = 0; i < NREF; i++) begin : g_cmp
      assign eq[i]  = (tmr == refv[i]);
      // only the first cycle of equality counts
      assign hit[i] = run & eq[i] & ~eq_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) eq_q[i] <= 1'b0;
         else        eq_q[i] <= eq[i];
      end
   end

   assign hit_pri = hit[0];
   assign hit_sec = hit[1];

   assert_pri_single_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_pri |=> !hit_pri);
   assert_sec_single_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_sec |=> !hit_sec);
endmodule

// File: rtl/ocmp_irq.sv
module ocmp_irq
   import ocmp_pkg::*;
(
   input  oc_mode_e mode,
   input  logic     pin_old,
   input  logic     pin_new,
   input  logic     flag_old,
   input  logic     flag_new,
   output logic     fire
);
   logic rise, fall;

   assign rise = pin_new & ~pin_old;
   assign fall = pin_old & ~pin_new;

   always_comb begin
      unique case (mode)
         OC_SET1:                   fire = rise;
         OC_SET0, OC_DLY, OC_PULSE: fire = fall;
         OC_TOG:                    fire = rise | fall;
         OC_PWMF:                   fire = flag_new & ~flag_old;
         default:                   fire = 1'b0;
      endcase
   end
endmodule

// File: rtl/ocmp_wave.sv
module ocmp_wave
   import ocmp_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [2:0]    mode_new,
   input  logic [TW-1:0] pri_new,
   input  oc_mode_e      mode_q,
   input  logic          hit_pri,
   input  logic          hit_sec,
   input  logic          prd,
   input  logic          flt_s,
   input  logic          pin_now,
   output logic          pin_q,
   output logic          flag_q,
   output logic          irq_q
);
   logic pin_n, flag_n, done_q, done_n, fire;

   always_comb begin
      pin_n  = pin_q;
      flag_n = flag_q;
      done_n = done_q;
      if (load) begin
         flag_n = 1'b0;
         done_n = 1'b0;
         unique case (oc_mode_e'(mode_new))
            OC_SET0:        pin_n = 1'b1;
            OC_TOG:         pin_n = pin_now;
            OC_PWM, OC_PWMF: pin_n = |pri_new;
            default:        pin_n = 1'b0;
         endcase
      end else begin
         unique case (mode_q)
            OC_SET1:  if (hit_pri) pin_n = 1'b1;
            OC_SET0:  if (hit_pri) pin_n = 1'b0;
            OC_TOG:   if (hit_pri) pin_n = ~pin_q;
            OC_DLY:
               if (!done_q) begin
                  if (hit_sec && pin_q) begin
                     pin_n  = 1'b0;
                     done_n = 1'b1;
                  end else if (hit_pri) begin
                     pin_n = 1'b1;
                  end
               end
            OC_PULSE:
               if (hit_sec)      pin_n = 1'b0;
               else if (hit_pri) pin_n = 1'b1;
            OC_PWM:
               if (prd)          pin_n = 1'b1;
               else if (hit_sec) pin_n = 1'b0;
            OC_PWMF:
               if (flag_q)       pin_n = 1'b0;
               else if (!flt_s) begin
                  flag_n = 1'b1;
                  pin_n  = 1'b0;
               end
               else if (prd)     pin_n = 1'b1;
               else if (hit_sec) pin_n = 1'b0;
            default: ;
         endcase
      end
   end

   ocmp_irq u_irq (
      .mode     (mode_q),
      .pin_old  (pin_q),
      .pin_new  (pin_n),
      .flag_old (flag_q),
      .flag_new (flag_n),
      .fire     (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         flag_q <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         pin_q  <= pin_n;
         flag_q <= flag_n;
         done_q <= done_n;
         irq_q  <= fire & ~load;
      end
   end

   assert_flag_forces_low_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |-> !pin_q);
   assert_flag_only_pwmf_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |-> (mode_q == OC_PWMF));
   assert_quiet_off_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OC_OFF) |-> !irq_q);
   assert_pwm_no_irq_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OC_PWM) |-> !irq_q);
   assert_oneshot_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OC_SET1 && pin_q && !load) |=> pin_q);
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
   import ocmp_pkg::*;
#(
   parameter int TW       = 16,
   parameter bit FLT_SYNC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tmr_val,
   input  logic          tmr_run,
   input  logic          prd_hit,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_mode,
   input  logic [TW-1:0] cfg_pri,
   input  logic [TW-1:0] cfg_sec,
   input  logic          flt_n,
   input  logic          gpio_lvl,
   output logic          oc_pin,
   output logic          oc_irq,
   output logic          flt_flag
);
   if (TW < 2 || TW > 32) begin : g_bad_tw
      $error("ocmp_unit: TW must lie in 2..32");
   end

   oc_mode_e      mode_q;
   logic [TW-1:0] pri_q, sec_q;
   logic          load, hit_pri, hit_sec, pin_q, flt_s;

   ocmp_cfg #(.TW(TW)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .run    (tmr_run),
      .mode_i (cfg_mode),
      .pri_i  (cfg_pri),
      .sec_i  (cfg_sec),
      .mode_q (mode_q),
      .pri_q  (pri_q),
      .sec_q  (sec_q),
      .load   (load)
   );

   ocmp_match #(.TW(TW)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tmr_run),
      .tmr     (tmr_val),
      .pri     (pri_q),
      .sec     (sec_q),
      .hit_pri (hit_pri),
      .hit_sec (hit_sec)
   );

   if (FLT_SYNC) begin : g_flt_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flt_s <= 1'b1;
         else        flt_s <= flt_n;
      end
   end else begin : g_flt_direct
      assign flt_s = flt_n;
   end

   assign oc_pin = (mode_q == OC_OFF) ? gpio_lvl : pin_q;

   ocmp_wave #(.TW(TW)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .mode_new (cfg_mode),
      .pri_new  (cfg_pri),
      .mode_q   (mode_q),
      .hit_pri  (hit_pri),
      .hit_sec  (hit_sec),
      .prd      (prd_hit),
      .flt_s    (flt_s),
      .pin_now  (oc_pin),
      .pin_q    (pin_q),
      .flag_q   (flt_flag),
      .irq_q    (oc_irq)
   );
endmodule

// File: tb/sim_ocmp_unit.sv
`timescale 1ns/1ps
module sim_ocmp_unit;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] tmr_val = '1;
   logic          tmr_run = 1'b0, prd_hit = 1'b0, cfg_we = 1'b0;
   logic [2:0]    cfg_mode = 3'd0;
   logic [TW-1:0] cfg_pri = '0, cfg_sec = '0;
   logic          flt_n = 1'b1, gpio_lvl = 1'b0;
   logic          oc_pin, oc_irq, flt_flag;

   int total = 0, bad = 0;

   // cycle model state, built from the requirements
   logic [2:0]    m_mode = 3'd0;
   logic [TW-1:0] m_r = '0, m_rs = '0;
   logic          m_pin = 0, m_flag = 0, m_done = 0, m_irq = 0, m_flts = 1;
   logic          m_eqr = 0, m_eqs = 0, m_loaded = 0;

   always #2.5 clk = ~clk;

   ocmp_unit #(.TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .tmr_run(tmr_run),
      .prd_hit(prd_hit), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_pri(cfg_pri), .cfg_sec(cfg_sec), .flt_n(flt_n),
      .gpio_lvl(gpio_lvl), .oc_pin(oc_pin), .oc_irq(oc_irq),
      .flt_flag(flt_flag)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   function automatic string pin_tag(input logic [2:0] md);
      case (md)
         3'd0:       return "R1";
         3'd1, 3'd2: return "R4";
         3'd3:       return "R5";
         3'd4:       return "R6";
         3'd5:       return "R7";
         3'd6:       return "R8";
         default:    return "R9";
      endcase
   endfunction

   // advance one clock: predict, step, then compare away from the edge
   task automatic tick();
      logic ld, hr, hs, np, nf, nd, outp;
      ld   = cfg_we && !tmr_run;
      outp = (m_mode == 3'd0) ? gpio_lvl : m_pin;
      hr   = tmr_run && (tmr_val == m_r) && !m_eqr;
      hs   = tmr_run && (tmr_val == m_rs) && !m_eqs;
      np = m_pin; nf = m_flag; nd = m_done;
      if (ld) begin
         nf = 0; nd = 0;
         case (cfg_mode)
            3'd2:       np = 1'b1;
            3'd3:       np = outp;
            3'd6, 3'd7: np = (cfg_pri != 0);
            default:    np = 1'b0;
         endcase
      end else begin
         case (m_mode)
            3'd1: if (hr) np = 1;
            3'd2: if (hr) np = 0;
            3'd3: if (hr) np = ~m_pin;
            3'd4: if (!m_done) begin
                     if (hs && m_pin) begin np = 0; nd = 1; end
                     else if (hr) np = 1;
                  end
            3'd5: if (hs) np = 0; else if (hr) np = 1;
            3'd6: if (prd_hit) np = 1; else if (hs) np = 0;
            3'd7: if (m_flag) np = 0;
                  else if (!m_flts) begin nf = 1; np = 0; end
                  else if (prd_hit) np = 1;
                  else if (hs) np = 0;
            default: ;
         endcase
      end
      if (ld) m_irq = 0;
      else case (m_mode)
         3'd1:             m_irq = np & ~m_pin;
         3'd2, 3'd4, 3'd5: m_irq = ~np & m_pin;
         3'd3:             m_irq = np ^ m_pin;
         3'd7:             m_irq = nf & ~m_flag;
         default:          m_irq = 0;
      endcase
      m_eqr = (tmr_val == m_r);
      m_eqs = (tmr_val == m_rs);
      m_flts = flt_n;
      m_pin = np; m_flag = nf; m_done = nd; m_loaded = ld;
      if (ld) begin m_mode = cfg_mode; m_r = cfg_pri; m_rs = cfg_sec; end
      @(posedge clk);
      #1;
      if (m_loaded && m_mode >= 3'd6)
         chk("R3 pin after load", oc_pin, m_pin);
      else if (m_loaded)
         chk("R2 pin after load", oc_pin, (m_mode == 0) ? gpio_lvl : m_pin);
      else
         chk({pin_tag(m_mode), " pin"}, oc_pin, (m_mode == 0) ? gpio_lvl : m_pin);
      chk("R10 irq", oc_irq, m_irq);
      chk("R9 fault flag", flt_flag, m_flag);
   endtask

   task automatic load_cfg(input logic [2:0] md, input int r, input int rs);
      tmr_run = 0; tmr_val = '1; prd_hit = 0;
      cfg_we = 1; cfg_mode = md; cfg_pri = TW'(r); cfg_sec = TW'(rs);
      tick();
      cfg_we = 0;
   endtask

   // run the timer 0..per for n cycles; fault low for 3 cycles at fidx
   task automatic run_tmr(input int n, input int per, input int fidx);
      int t = 0;
      for (int c = 0; c < n; c++) begin
         tmr_run = 1;
         tmr_val = TW'(t);
         prd_hit = (t == per);
         flt_n   = !(c >= fidx && c < fidx + 3);
         tick();
         t = (t == per) ? 0 : t + 1;
      end
      tmr_run = 0; prd_hit = 0; tmr_val = '1; flt_n = 1;
      tick();
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R13: reset state
      gpio_lvl = 1; #0.5;
      chk("R13 pin follows gpio in reset", oc_pin, 1'b1);
      chk("R13 irq low in reset", oc_irq, 1'b0);
      chk("R13 flag low in reset", flt_flag, 1'b0);
      rst_n = 1;
      tick();

      // R1: disabled mode with running timer and changing gpio
      load_cfg(3'd0, 3, 5);
      for (int c = 0; c < 12; c++) begin
         gpio_lvl = c[1];
         tmr_run = 1; tmr_val = TW'(c % 6); prd_hit = (c % 6 == 5);
         tick();
      end
      tmr_run = 0; prd_hit = 0; tmr_val = '1;

      // R2: toggle mode keeps the gpio level present before the write
      gpio_lvl = 1;
      tick();
      load_cfg(3'd3, 4, 6);
      chk("R2 toggle keeps prior level", oc_pin, 1'b1);
      run_tmr(20, 9, 1000);

      // sweep of modes 1..7 over compare values, including equal ones
      for (int md = 1; md < 8; md++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 4; b++) begin
               load_cfg(3'(md), a * 4, (b == 3) ? 10 : 1 + b * 3);
               run_tmr(34, 10, (a == 2) ? 15 : 1000);
            end

      // R9: flag cleared by rewrite
      load_cfg(3'd7, 2, 5);
      run_tmr(8, 6, 2);
      chk("R9 flag held after fault", flt_flag, 1'b1);
      chk("R9 pin low while flagged", oc_pin, 1'b0);
      load_cfg(3'd7, 2, 5);
      chk("R9 flag cleared by write", flt_flag, 1'b0);

      // R11: write while running is ignored
      load_cfg(3'd3, 3, 7);
      run_tmr(5, 9, 1000);
      gpio_lvl = ~oc_pin;
      tmr_run = 1; tmr_val = 16'd20; cfg_we = 1; cfg_mode = 3'd0;
      cfg_pri = 16'd20;
      tick();
      cfg_we = 0;
      chk("R11 running write ignored", oc_pin, ~gpio_lvl);
      tmr_val = 16'd3;
      tick();
      chk("R11 old compare value still active", oc_pin, gpio_lvl);

      // R12: timer held on the primary value gives one match
      tmr_run = 0; tmr_val = '1;
      tick();
      load_cfg(3'd3, 5, 9);
      begin
         logic p0;
         p0 = oc_pin;
         tmr_run = 1;
         for (int c = 0; c < 4; c++) begin
            tmr_val = 16'd5;
            tick();
         end
         chk("R12 held timer toggles once", oc_pin, ~p0);
         tmr_run = 0; tmr_val = 16'd5;
         tick();
         tmr_val = 16'd6; tick();
         tmr_val = 16'd5; tick();
         chk("R12 stopped timer gives no match", oc_pin, ~p0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule